// File: doc/BRIEF.md
# Configurable Audio Serial Transmitter

This block serializes stereo PCM samples onto a single data line. Samples come from a 16-word transmit FIFO. Each FIFO word carries one channel sample, and consecutive words alternate left, then right. Bits leave the block aligned to a bit-clock enable strobe and a word-select level. Each change of word-select level starts a half-frame, and every half-frame is `HALF_BITS` bit periods long. The strobe and the level come from one of two sources. In master mode they come from the on-chip clock generator; in slave mode they come from pins driven by an external device.

Configuration inputs select:
- the framing style: delayed-MSB I2S, left-justified or right-justified;
- an inversion of the word-select sense;
- a sample width of 8, 16 or 24 bits. A width write with any other value is refused.

Software fills the FIFO and then raises the active control. Transmission begins on the next left half-frame. When the active control drops, transmission continues until the next frame boundary and then stops. A flush pulse empties the FIFO at once. If the FIFO runs dry while transmitting, the block sends silence and raises a sticky underrun flag.

Top module: `audio_ser_tx`

## Requirements
- R1: The FIFO holds 16 words. `fifo_count` (5 bits) reports its occupancy and `fifo_full` is high at 16 words. A push while full is discarded, and the discarded word is never transmitted.
- R2: A one-cycle `flush` empties the FIFO on the next clock edge, even when a push arrives in the same cycle. None of the flushed words is transmitted.
- R3: The width register resets to 16. A `width_wr` with `width_val` equal to 8, 16 or 24 sets it. Any other value leaves it unchanged. `width_cur` shows the register, and sample bits [W-1:0] of a word are sent, MSB first.
- R4: With `cfg_fmt`=0 (I2S), the left channel occupies word-select low. The sample MSB is on bit position 1 of the half-frame, where position 0 is the first bit strobe after the word-select change.
- R5: With `cfg_fmt`=1 (left-justified), the left channel occupies word-select high, and the MSB is on position 0.
- R6: With `cfg_fmt`=2 (right-justified), the left channel occupies word-select high, and the LSB is on the last position, HALF_BITS-1.
- R7: `cfg_ws_inv`=1 swaps which word-select level carries the left channel in every format.
- R8: Raising `cfg_active` starts transmission at the next left half-frame. Dropping it stops transmission at the next left half-frame start. `tx_running` shows the state, and `sd_out` stays 0 while stopped.
- R9: While running, each half-frame consumes exactly one FIFO word, in push order. Positions outside the sample window carry 0.
- R10: A half-frame that starts while running with the FIFO empty sends all zeros and sets `underrun`. The flag stays set until an `underrun_clr` pulse.
- R11: `cfg_master`=1 takes the bit strobe and word-select from `m_bclk_en`/`m_ws`. `cfg_master`=0 takes them from `s_bclk_en`/`s_ws`. The unselected pair has no effect on `sd_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified |
| cfg_ws_inv | input | 1 | Invert word-select sense |
| cfg_master | input | 1 | 1 selects the internal strobe pair, 0 the external pair |
| cfg_active | input | 1 | Transmit enable; low requests a pause |
| width_wr | input | 1 | Write strobe for the sample-width register |
| width_val | input | 5 | Requested sample width in bits |
| width_cur | output | 5 | Current sample width |
| push | input | 1 | Write one word into the FIFO |
| push_data | input | DATA_W | Sample word |
| flush | input | 1 | Empty the FIFO |
| m_bclk_en | input | 1 | Bit strobe from the internal generator |
| m_ws | input | 1 | Word-select level from the internal generator |
| s_bclk_en | input | 1 | Bit strobe from the external device |
| s_ws | input | 1 | Word-select level from the external device |
| underrun_clr | input | 1 | Clear the underrun flag |
| sd_out | output | 1 | Serial data |
| fifo_count | output | CNT_W | FIFO occupancy |
| fifo_full | output | 1 | FIFO full |
| underrun | output | 1 | Sticky underrun flag |
| tx_running | output | 1 | High while transmitting, low while paused |

## Verification
The hardest condition to reach is the stop decision. The block may stop only where the chosen format and polarity put a left half-frame, and that point moves whenever the format or the inversion changes. The stimulus covers this in two ways. It runs every format in both polarities and in both clock-source modes. In each run it drops the active control part-way through a frame and then keeps strobing, so the final right half and the silent halves after it are captured bit by bit. A separate run drains the FIFO on purpose to reach the underrun path, because normal stimulus never lets the FIFO empty.

// File: rtl/audio_tx_pkg.sv
// Shared types and helpers for the audio serial transmitter.
// Assumes: callers pass widths as plain bit counts.
package audio_tx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_SPARE = 2'd3
    } fmt_e;

    // True when the requested sample width is one the serializer supports.
    function automatic logic width_legal(input logic [4:0] w);
        return (w == 5'd8) || (w == 5'd16) || (w == 5'd24);
    endfunction

endpackage

// File: rtl/atx_fifo.sv
// Transmit sample FIFO: circular buffer with occupancy count.
// Assumes: flush wins over push/pop; pushes while full are dropped.
module atx_fifo #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/atx_frame.sv
// Frame tracker: picks the strobe source, finds word-select changes and
// counts the bit position inside the current half-frame.
// Assumes: word-select only changes together with a bit strobe.
module atx_frame #(
    parameter int HALF_BITS = 32,
    localparam int POS_W = $clog2(HALF_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic             m_bclk_en,
    input  logic             m_ws,
    input  logic             s_bclk_en,
    input  logic             s_ws,
    output logic             bclk_en,
    output logic             ws_now,
    output logic             half_start,
    output logic [POS_W-1:0] pos_next
);
    logic             ws_prev;
    logic [POS_W-1:0] pos_q;

    assign bclk_en    = master ? m_bclk_en : s_bclk_en;
    assign ws_now     = master ? m_ws : s_ws;
    assign half_start = bclk_en && (ws_now != ws_prev);

    // Next position: restart at a word-select change, else advance and saturate.
    always_comb begin
        if (ws_now != ws_prev)
            pos_next = '0;
        else if (pos_q == POS_W'(HALF_BITS))
            pos_next = pos_q;
        else
            pos_next = pos_q + 1'b1;
    end

    // Track the last word-select level and the position on each bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev <= 1'b0;
            pos_q   <= POS_W'(HALF_BITS);
        end else if (bclk_en) begin
            ws_prev <= ws_now;
            pos_q   <= pos_next;
        end
    end

endmodule

// File: rtl/atx_shift.sv
// Serializer: holds the word of the current half-frame and drives the bit
// that the framing style puts at each position.
// Assumes: width never exceeds DATA_W; positions beyond the window send 0.
module atx_shift
    import audio_tx_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int HALF_BITS = 32,
    localparam int POS_W    = $clog2(HALF_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_en,
    input  logic              half_start,
    input  logic [DATA_W-1:0] load_word,
    input  logic [POS_W-1:0]  pos_next,
    input  logic [4:0]        width,
    input  fmt_e              fmt,
    output logic              sd
);
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_sel;
    logic              bit_now;

    // Bit of the word placed at a given position for the selected style.
    function automatic logic pick_bit(input logic [DATA_W-1:0] w_in,
                                      input int p, input int w, input fmt_e f);
        int                idx;
        logic [DATA_W-1:0] sh;
        idx = -1;
        case (f)
            FMT_I2S:   if (p >= 1 && p <= w) idx = w - p;
            FMT_RIGHT: if (p >= HALF_BITS - w && p < HALF_BITS) idx = HALF_BITS - 1 - p;
            default:   if (p < w) idx = w - 1 - p;
        endcase
        if (idx < 0 || idx >= DATA_W)
            return 1'b0;
        sh = w_in >> idx;
        return sh[0];
    endfunction

    assign word_sel = half_start ? load_word : word_q;
    assign bit_now  = pick_bit(word_sel, int'(pos_next), int'(width), fmt);

    // Register the data bit and latch the new word at each half-frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            sd     <= 1'b0;
        end else if (bclk_en) begin
            sd <= bit_now;
            if (half_start)
                word_q <= load_word;
        end
    end

endmodule

// File: rtl/audio_ser_tx.sv
// Audio serial transmitter top: FIFO, frame tracker, serializer and the
// run/pause, width and underrun control.
// Assumes: every half-frame is HALF_BITS strobes long; FIFO words alternate
// left then right, and running always begins on a left half-frame.
module audio_ser_tx
    import audio_tx_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int DEPTH     = 16,
    parameter int HALF_BITS = 32,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int POS_W    = $clog2(HALF_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fmt,
    input  logic              cfg_ws_inv,
    input  logic              cfg_master,
    input  logic              cfg_active,
    input  logic              width_wr,
    input  logic [4:0]        width_val,
    output logic [4:0]        width_cur,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              flush,
    input  logic              m_bclk_en,
    input  logic              m_ws,
    input  logic              s_bclk_en,
    input  logic              s_ws,
    input  logic              underrun_clr,
    output logic              sd_out,
    output logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_full,
    output logic              underrun,
    output logic              tx_running
);
    fmt_e              fmt;
    logic [4:0]        width_q;
    logic              run_q, run_next;
    logic              fifo_empty, pop_w, under_set, left_next;
    logic              bclk_en, ws_now, half_start;
    logic [POS_W-1:0]  pos_next;
    logic [DATA_W-1:0] head, load_word;

    assign fmt        = fmt_e'(cfg_fmt);
    assign width_cur  = width_q;
    assign tx_running = run_q;

    atx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
        .push_data(push_data), .pop(pop_w), .head(head),
        .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
    );

    atx_frame #(.HALF_BITS(HALF_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .master(cfg_master),
        .m_bclk_en(m_bclk_en), .m_ws(m_ws), .s_bclk_en(s_bclk_en), .s_ws(s_ws),
        .bclk_en(bclk_en), .ws_now(ws_now), .half_start(half_start),
        .pos_next(pos_next)
    );

    atx_shift #(.DATA_W(DATA_W), .HALF_BITS(HALF_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .half_start(half_start),
        .load_word(load_word), .pos_next(pos_next), .width(width_q),
        .fmt(fmt), .sd(sd_out)
    );

    // Channel of the half-frame now starting: I2S puts left on low, the
    // justified styles on high; the invert control swaps either.
    assign left_next = ((fmt == FMT_I2S) ? ~ws_now : ws_now) ^ cfg_ws_inv;

    // Run state may change only where a left half-frame begins.
    always_comb begin
        run_next = run_q;
        if (half_start && left_next)
            run_next = cfg_active;
    end

    assign pop_w     = half_start && run_next && !fifo_empty;
    assign under_set = half_start && run_next && fifo_empty;
    assign load_word = pop_w ? head : '0;

    // Run/pause state register.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_next;
    end

    // Sample-width register; unsupported values are refused.
    always_ff @(posedge clk) begin
        if (!rst_n)
            width_q <= 5'd16;
        else if (width_wr && width_legal(width_val))
            width_q <= width_val;
    end

    // Sticky underrun flag; a new underrun wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            underrun <= 1'b0;
        else if (under_set)    underrun <= 1'b1;
        else if (underrun_clr) underrun <= 1'b0;
    end

endmodule

// File: rtl/audio_ser_tx_chk.sv
// Property checker for the audio serial transmitter, bound to the top.
// Assumes: connected to the top's ports and control nets by the bind below.
module audio_ser_tx_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop_w,
    input logic             flush,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_count,
    input logic [4:0]       width_q,
    input logic             half_start,
    input logic             run_q,
    input logic             run_next,
    input logic             bclk_en,
    input logic             sd_out,
    input logic             underrun,
    input logic             underrun_clr,
    input logic             fifo_empty
);
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    assert_drop_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && push && !pop_w && !flush) |=> (fifo_count == $past(fifo_count)));

    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_count == '0));

    assert_width_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (width_q == 5'd8) || (width_q == 5'd16) || (width_q == 5'd24));

    assert_run_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !half_start |=> $stable(run_q));

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && !run_next) |=> !sd_out);

    assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !underrun_clr) |=> underrun);

    assert_underrun_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (half_start && run_next && fifo_empty) |=> (underrun && !sd_out));

endmodule

bind audio_ser_tx audio_ser_tx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop_w(pop_w), .flush(flush),
    .fifo_full(fifo_full), .fifo_count(fifo_count), .width_q(width_q),
    .half_start(half_start), .run_q(run_q), .run_next(run_next),
    .bclk_en(bclk_en), .sd_out(sd_out), .underrun(underrun),
    .underrun_clr(underrun_clr), .fifo_empty(fifo_empty)
);

// File: tb/audio_ser_tx_tb.sv
// Self-checking bench: seeded random samples and configurations plus
// directed corner cases, compared against a bench-side frame model.
module audio_ser_tx_tb;
    localparam int DW = 24;
    localparam int DEPTH = 16;
    localparam int H = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_fmt = 2'd0;
    logic cfg_ws_inv = 1'b0, cfg_master = 1'b1, cfg_active = 1'b0;
    logic width_wr = 1'b0;
    logic [4:0] width_val = 5'd0;
    logic [4:0] width_cur;
    logic push = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic flush = 1'b0;
    logic m_bclk_en = 1'b0, m_ws = 1'b0, s_bclk_en = 1'b0, s_ws = 1'b0;
    logic underrun_clr = 1'b0;
    logic sd_out;
    logic [4:0] fifo_count;
    logic fifo_full, underrun, tx_running;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] mq[$];
    logic m_run = 1'b0;
    logic ws_lvl = 1'b0;
    int cur_w = 16;
    logic slave = 1'b0;

    always #10 clk = ~clk;

    audio_ser_tx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_ws_inv(cfg_ws_inv),
        .cfg_master(cfg_master), .cfg_active(cfg_active), .width_wr(width_wr),
        .width_val(width_val), .width_cur(width_cur), .push(push),
        .push_data(push_data), .flush(flush), .m_bclk_en(m_bclk_en), .m_ws(m_ws),
        .s_bclk_en(s_bclk_en), .s_ws(s_ws), .underrun_clr(underrun_clr),
        .sd_out(sd_out), .fifo_count(fifo_count), .fifo_full(fifo_full),
        .underrun(underrun), .tx_running(tx_running)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected half-frame bit vector, indexed by position after the ws change.
    function automatic logic [H-1:0] exp_vec(input logic [DW-1:0] w,
                                             input int fmt, input int wd);
        logic [H-1:0] v = '0;
        int start = (fmt == 0) ? 1 : (fmt == 2) ? H - wd : 0;
        for (int k = 0; k < wd; k++) v[start + k] = w[wd - 1 - k];
        return v;
    endfunction

    task automatic push_word(input logic [DW-1:0] d);
        @(negedge clk); push = 1'b1; push_data = d;
        @(negedge clk); push = 1'b0;
        if (mq.size() < DEPTH) mq.push_back(d);
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        mq.delete();
    endtask

    task automatic set_width(input logic [4:0] v);
        @(negedge clk); width_wr = 1'b1; width_val = v;
        @(negedge clk); width_wr = 1'b0;
        if (v == 5'd8 || v == 5'd16 || v == 5'd24) cur_w = int'(v);
    endtask

    task automatic tick(input logic ws, output logic b);
        @(negedge clk);
        if (slave) begin s_bclk_en = 1'b1; s_ws = ws; m_ws = 1'($urandom); end
        else       begin m_bclk_en = 1'b1; m_ws = ws; s_ws = 1'($urandom); end
        @(negedge clk);
        m_bclk_en = 1'b0; s_bclk_en = 1'b0;
        b = sd_out;
    endtask

    // One half-frame: update the model, strobe H bits, compare the stream.
    task automatic run_half();
        logic left, b;
        logic [DW-1:0] w;
        logic [H-1:0] cap;
        logic [H-1:0] ev;
        string tag;
        int f = int'(cfg_fmt);
        ws_lvl = ~ws_lvl;
        left = ((f == 0) ? ~ws_lvl : ws_lvl) ^ cfg_ws_inv;
        if (left) m_run = cfg_active;
        w = '0;
        if (m_run && mq.size() > 0) w = mq.pop_front();
        for (int p = 0; p < H; p++) begin
            tick(ws_lvl, b);
            cap[p] = b;
        end
        ev = exp_vec(w, f, cur_w);
        tag = (f == 0) ? "R4 R9 I2S stream" : (f == 1) ? "R5 R9 left-justified stream"
                                                      : "R6 R9 right-justified stream";
        if (cfg_ws_inv) tag = {tag, " R7 inverted"};
        if (slave) tag = {tag, " R11 slave"};
        check(cap == ev, tag, 64'(cap), 64'(ev));
        check(tx_running == m_run, "R8 running state", 64'(tx_running), 64'(m_run));
    endtask

    task automatic run_cfg(input int fmt, input bit inv, input logic [4:0] wd,
                           input bit slv);
        cfg_active = 1'b0;
        do_flush();
        check(fifo_count == 0, "R2 flush empties", 64'(fifo_count), 64'd0);
        set_width(wd);
        cfg_fmt = 2'(fmt); cfg_ws_inv = inv; slave = slv; cfg_master = ~slv;
        for (int i = 0; i < DEPTH; i++) push_word(DW'($urandom));
        cfg_active = 1'b1;
        for (int h = 0; h < 13; h++) run_half();
        cfg_active = 1'b0;
        for (int h = 0; h < 4; h++) run_half();
    endtask

    initial begin
        int seed;
        seed = $urandom(1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fifo_count == 0, "R1 reset count", 64'(fifo_count), 64'd0);
        check(fifo_full == 0, "R1 reset full", 64'(fifo_full), 64'd0);
        check(tx_running == 0, "R8 reset idle", 64'(tx_running), 64'd0);
        check(sd_out == 0, "R8 reset data", 64'(sd_out), 64'd0);
        check(underrun == 0, "R10 reset flag", 64'(underrun), 64'd0);
        check(width_cur == 16, "R3 reset width", 64'(width_cur), 64'd16);

        // R3: legal and illegal widths.
        set_width(5'd12);
        check(width_cur == 16, "R3 reject 12", 64'(width_cur), 64'd16);
        set_width(5'd24);
        check(width_cur == 24, "R3 accept 24", 64'(width_cur), 64'd24);
        set_width(5'd0);
        check(width_cur == 24, "R3 reject 0", 64'(width_cur), 64'd24);
        set_width(5'd31);
        check(width_cur == 24, "R3 reject 31", 64'(width_cur), 64'd24);
        set_width(5'd8);
        check(width_cur == 8, "R3 accept 8", 64'(width_cur), 64'd8);

        // R1: fill to full, then a dropped push.
        for (int i = 0; i < DEPTH; i++) push_word(DW'($urandom));
        check(fifo_full == 1, "R1 full flag", 64'(fifo_full), 64'd1);
        check(fifo_count == 16, "R1 count at full", 64'(fifo_count), 64'd16);
        push_word(24'hABCDEF);
        check(fifo_count == 16, "R1 push when full dropped", 64'(fifo_count), 64'd16);

        // R2: flush with a simultaneous push.
        @(negedge clk); flush = 1'b1; push = 1'b1; push_data = 24'h123456;
        @(negedge clk); flush = 1'b0; push = 1'b0;
        mq.delete();
        check(fifo_count == 0, "R2 flush beats push", 64'(fifo_count), 64'd0);

        // Directed format and polarity runs, both clock sources.
        run_cfg(0, 1'b0, 5'd16, 1'b0);
        run_cfg(1, 1'b0, 5'd24, 1'b0);
        run_cfg(2, 1'b0, 5'd8, 1'b0);
        run_cfg(0, 1'b1, 5'd24, 1'b1);
        run_cfg(2, 1'b1, 5'd16, 1'b1);
        run_cfg(1, 1'b1, 5'd8, 1'b1);
        // Random configurations.
        for (int r = 0; r < 4; r++) begin
            int wsel = int'($urandom_range(0, 2));
            run_cfg(int'($urandom_range(0, 2)), 1'($urandom), 5'(8 * (wsel + 1)),
                    1'($urandom));
        end

        // R10: drain the FIFO while running.
        cfg_active = 1'b0; do_flush();
        cfg_fmt = 2'd1; cfg_ws_inv = 1'b0; slave = 1'b0; cfg_master = 1'b1;
        set_width(5'd16);
        for (int i = 0; i < 3; i++) push_word(DW'($urandom));
        cfg_active = 1'b1;
        for (int h = 0; h < 7; h++) run_half();
        check(underrun == 1, "R10 underrun raised", 64'(underrun), 64'd1);
        run_half();
        check(underrun == 1, "R10 underrun sticky", 64'(underrun), 64'd1);
        cfg_active = 1'b0;
        for (int h = 0; h < 3; h++) run_half();
        @(negedge clk); underrun_clr = 1'b1;
        @(negedge clk); underrun_clr = 1'b0;
        check(underrun == 0, "R10 underrun cleared", 64'(underrun), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule